// File: doc/BRIEF.md
# Serial Option Loader and Receiver Power-Up Sequencer

This block takes a fixed-length configuration word from a host over a slow two-wire serial link (a clock line and a data line) right after reset. It samples both lines with its own faster system clock, shifts in one bit on each rising edge of the serial clock, and reports when the whole word has arrived. The complete option word stays visible on an output bus for the rest of the chip. After the last bit, any further serial clock pulses are ignored until the next reset.

Once the word is complete, the block runs the power-up sequence for a radio receiver. With the run request low it stays in standby with everything off. When the run request goes high it first asks for the oscillator. It then waits for the oscillator-ready input. After that it switches on four enables in a fixed order: the synthesizer supply, the RF stage, and two demodulator controls. Each enable follows the one before it after a lead time, and a single option bit picks that lead time from two parameter values. Each of the four enables has its own programmable active level. Two auxiliary indicator lines follow the demodulator controls, and one option bit gates them. Dropping the run request returns every output to its inactive level and keeps the loaded options.

Top module: `opt_rx_seq`

## Requirements
- R1: After reset, OPT_BITS serial clock rising edges shift the data line into `opt_reg`: the k-th bit received lands at `opt_reg[k]` (first bit at index 0). `load_done` rises after the last one.
- R2: Once `load_done` is high, further serial clock pulses leave `opt_reg` unchanged and `load_done` high until the next reset.
- R3: While reset is high and until `load_done` rises, `osc_en` and all six enable and auxiliary outputs are driven 0 and `load_done` is 0.
- R4: With `load_done` high and `run_req` low the block is in standby: `osc_en` is 0 and each enable sits at its inactive level. When `run_req` is high, `osc_en` is 1.
- R5: No enable becomes active before `osc_ready` is seen. `pll_en` becomes active 3+T0 clock cycles after `osc_ready` rises. T0 is LEAD_PL_B if option bit 5 is 1, else LEAD_PL_A.
- R6: `rf_en` becomes active T1 cycles after `pll_en`. T1 is LEAD_RF_B if option bit 6 is 1, else LEAD_RF_A.
- R7: `dmd1_en` becomes active T2 cycles after `rf_en`. T2 is LEAD_Q1_B if option bit 7 is 1, else LEAD_Q1_A.
- R8: `dmd2_en` becomes active T3 cycles after `dmd1_en`. T3 is LEAD_Q2_B if option bit 8 is 1, else LEAD_Q2_A.
- R9: Option bits 0, 1, 2 and 3 set the active level of `rf_en`, `pll_en`, `dmd1_en` and `dmd2_en`. A 1 means active-high. After load the inactive level is the inverse of that bit.
- R10: The aux gate is option bit 4. With the gate at 1, `aux_a` is 1 exactly while the first demodulator control is active and `aux_b` is the inverse of `dmd2_en`. With the gate at 0, both are 0.
- R11: When `run_req` falls, all enables return to inactive and `osc_en` to 0 within 3 cycles, and `opt_reg` is kept. When `run_req` rises again with the oscillator already ready, `pll_en` becomes active 4+T0 cycles later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial option clock from host (asynchronous, slow) |
| ser_data | input | 1 | Serial option data, sampled on ser_clk rising edge |
| run_req | input | 1 | Run request; low selects standby |
| osc_ready | input | 1 | Oscillator-stable indication |
| osc_en | output | 1 | Oscillator request |
| load_done | output | 1 | All option bits received |
| opt_reg | output | OPT_BITS | Loaded option word |
| pll_en | output | 1 | Synthesizer supply enable |
| rf_en | output | 1 | RF stage enable |
| dmd1_en | output | 1 | First demodulator control |
| dmd2_en | output | 1 | Second demodulator control |
| aux_a | output | 1 | Auxiliary indicator, active-high |
| aux_b | output | 1 | Auxiliary indicator, inverse of dmd2_en |

## Verification
The bench builds the block with the full 192-bit option word. Its lead times are small and distinct: 2/5, 3/7, 1/4 and 2/6 cycles. With these values every lead choice gives its own exact delay, and a full power-up sequence settles in a few dozen cycles. So the bench can sweep all sixteen combinations of the four lead-select bits, all sixteen polarity patterns and both settings of the aux gate across thirty-two complete load and power-up runs. Each run also covers extra serial pulses, a run-request drop and a restart.

// File: rtl/opt_rx_pkg.sv
package opt_rx_pkg;

    typedef enum logic [2:0] {
        ST_LOAD    = 3'd0,
        ST_STBY    = 3'd1,
        ST_OSC     = 3'd2,
        ST_LEAD_PL = 3'd3,
        ST_LEAD_RF = 3'd4,
        ST_LEAD_Q1 = 3'd5,
        ST_LEAD_Q2 = 3'd6,
        ST_RUN     = 3'd7
    } seq_state_e;

    // Decoded option fields
    typedef struct packed {
        logic pl_pol;
        logic rf_pol;
        logic q1_pol;
        logic q2_pol;
        logic aux_gate;
        logic sel_pl;
        logic sel_rf;
        logic sel_q1;
        logic sel_q2;
    } opt_fields_t;

    // Logical (polarity-free) enable state
    typedef struct packed {
        logic pl;
        logic rf;
        logic q1;
        logic q2;
    } en_vec_t;

    // Pin level from logical activity and active level (1 = active-high)
    function automatic logic drive_level(input logic act, input logic pol);
        return ~(act ^ pol);
    endfunction

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/opt_rx_sync.sv
module opt_rx_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] d_sync
);
    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= d_async;
            stage2_q <= stage1_q;
        end
    end

    assign d_sync = stage2_q;
endmodule

// File: rtl/opt_rx_shift.sv
module opt_rx_shift #(
    parameter int OPT_BITS = 192
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                sclk_s,
    input  logic                sdat_s,
    output logic [OPT_BITS-1:0] opt_q,
    output logic                done
);
    localparam int CNTW = $clog2(OPT_BITS + 1);
    localparam logic [CNTW-1:0] LAST = CNTW'(OPT_BITS);

    logic            sclk_d;
    logic            sclk_rise;
    logic [CNTW-1:0] bit_cnt;

    assign sclk_rise = sclk_s & ~sclk_d;
    assign done      = (bit_cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_d  <= 1'b0;
            bit_cnt <= '0;
            opt_q   <= '0;
        end else begin
            sclk_d <= sclk_s;
            if (sclk_rise && !done) begin
                // newest bit enters at the top; first bit ends at index 0
                opt_q   <= {sdat_s, opt_q[OPT_BITS-1:1]};
                bit_cnt <= bit_cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/opt_rx_ctl.sv
module opt_rx_ctl
    import opt_rx_pkg::*;
#(
    parameter int unsigned LEAD_PL_A = 16,
    parameter int unsigned LEAD_PL_B = 64,
    parameter int unsigned LEAD_RF_A = 8,
    parameter int unsigned LEAD_RF_B = 32,
    parameter int unsigned LEAD_Q1_A = 4,
    parameter int unsigned LEAD_Q1_B = 24,
    parameter int unsigned LEAD_Q2_A = 4,
    parameter int unsigned LEAD_Q2_B = 40
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        load_done,
    input  logic        run_s,
    input  logic        osc_s,
    input  opt_fields_t fld,
    output logic        osc_en,
    output en_vec_t     act
);
    localparam int unsigned MAXL = max2(max2(max2(LEAD_PL_A, LEAD_PL_B), max2(LEAD_RF_A, LEAD_RF_B)),
                                        max2(max2(LEAD_Q1_A, LEAD_Q1_B), max2(LEAD_Q2_A, LEAD_Q2_B)));
    localparam int CW = $clog2(MAXL + 1);

    seq_state_e      state_q, state_d;
    logic [CW-1:0]   cnt_q, cnt_d;
    logic [CW-1:0]   lead_now;
    logic            in_lead;

    always_comb begin
        unique case (state_q)
            ST_LEAD_PL: lead_now = fld.sel_pl ? CW'(LEAD_PL_B) : CW'(LEAD_PL_A);
            ST_LEAD_RF: lead_now = fld.sel_rf ? CW'(LEAD_RF_B) : CW'(LEAD_RF_A);
            ST_LEAD_Q1: lead_now = fld.sel_q1 ? CW'(LEAD_Q1_B) : CW'(LEAD_Q1_A);
            ST_LEAD_Q2: lead_now = fld.sel_q2 ? CW'(LEAD_Q2_B) : CW'(LEAD_Q2_A);
            default:    lead_now = CW'(1);
        endcase
    end

    assign in_lead = (state_q >= ST_LEAD_PL) && (state_q <= ST_LEAD_Q2);

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_LOAD: begin
                if (load_done) state_d = run_s ? ST_OSC : ST_STBY;
            end
            ST_STBY: begin
                if (run_s) state_d = ST_OSC;
            end
            ST_OSC: begin
                if (osc_s) begin
                    state_d = ST_LEAD_PL;
                    cnt_d   = '0;
                end
            end
            ST_RUN: ;
            default: begin
                if (in_lead) begin
                    if (cnt_q == lead_now - 1'b1) begin
                        state_d = seq_state_e'(state_q + 3'd1);
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
        endcase
        // run request low aborts any active phase
        if (state_q != ST_LOAD && state_q != ST_STBY && !run_s) begin
            state_d = ST_STBY;
            cnt_d   = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_LOAD;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    assign osc_en = (state_q >= ST_OSC);
    assign act.pl = (state_q >= ST_LEAD_RF);
    assign act.rf = (state_q >= ST_LEAD_Q1);
    assign act.q1 = (state_q >= ST_LEAD_Q2);
    assign act.q2 = (state_q == ST_RUN);
endmodule

// File: rtl/opt_rx_seq.sv
module opt_rx_seq
    import opt_rx_pkg::*;
#(
    parameter int          OPT_BITS   = 192,
    parameter int          POS_RF_POL = 0,
    parameter int          POS_PL_POL = 1,
    parameter int          POS_Q1_POL = 2,
    parameter int          POS_Q2_POL = 3,
    parameter int          POS_AUX    = 4,
    parameter int          POS_SEL_PL = 5,
    parameter int          POS_SEL_RF = 6,
    parameter int          POS_SEL_Q1 = 7,
    parameter int          POS_SEL_Q2 = 8,
    parameter int unsigned LEAD_PL_A  = 16,
    parameter int unsigned LEAD_PL_B  = 64,
    parameter int unsigned LEAD_RF_A  = 8,
    parameter int unsigned LEAD_RF_B  = 32,
    parameter int unsigned LEAD_Q1_A  = 4,
    parameter int unsigned LEAD_Q1_B  = 24,
    parameter int unsigned LEAD_Q2_A  = 4,
    parameter int unsigned LEAD_Q2_B  = 40
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                ser_clk,
    input  logic                ser_data,
    input  logic                run_req,
    input  logic                osc_ready,
    output logic                osc_en,
    output logic                load_done,
    output logic [OPT_BITS-1:0] opt_reg,
    output logic                pll_en,
    output logic                rf_en,
    output logic                dmd1_en,
    output logic                dmd2_en,
    output logic                aux_a,
    output logic                aux_b
);
    localparam int NSYNC = 4;

    logic [NSYNC-1:0] raw_in, sync_out;
    logic             sclk_s, sdat_s, run_s, osc_s;
    logic             osc_req;
    opt_fields_t      fld;
    en_vec_t          act;

    assign raw_in = {osc_ready, run_req, ser_data, ser_clk};
    assign {osc_s, run_s, sdat_s, sclk_s} = sync_out;

    opt_rx_sync #(.W(NSYNC)) sync_i (
        .clk     (clk),
        .rst     (rst),
        .d_async (raw_in),
        .d_sync  (sync_out)
    );

    opt_rx_shift #(.OPT_BITS(OPT_BITS)) shift_i (
        .clk    (clk),
        .rst    (rst),
        .sclk_s (sclk_s),
        .sdat_s (sdat_s),
        .opt_q  (opt_reg),
        .done   (load_done)
    );

    assign fld.pl_pol   = opt_reg[POS_PL_POL];
    assign fld.rf_pol   = opt_reg[POS_RF_POL];
    assign fld.q1_pol   = opt_reg[POS_Q1_POL];
    assign fld.q2_pol   = opt_reg[POS_Q2_POL];
    assign fld.aux_gate = opt_reg[POS_AUX];
    assign fld.sel_pl   = opt_reg[POS_SEL_PL];
    assign fld.sel_rf   = opt_reg[POS_SEL_RF];
    assign fld.sel_q1   = opt_reg[POS_SEL_Q1];
    assign fld.sel_q2   = opt_reg[POS_SEL_Q2];

    opt_rx_ctl #(
        .LEAD_PL_A(LEAD_PL_A), .LEAD_PL_B(LEAD_PL_B),
        .LEAD_RF_A(LEAD_RF_A), .LEAD_RF_B(LEAD_RF_B),
        .LEAD_Q1_A(LEAD_Q1_A), .LEAD_Q1_B(LEAD_Q1_B),
        .LEAD_Q2_A(LEAD_Q2_A), .LEAD_Q2_B(LEAD_Q2_B)
    ) ctl_i (
        .clk       (clk),
        .rst       (rst),
        .load_done (load_done),
        .run_s     (run_s),
        .osc_s     (osc_s),
        .fld       (fld),
        .osc_en    (osc_req),
        .act       (act)
    );

    // Output stage: all low until the option word is complete
    assign osc_en  = load_done & osc_req;
    assign pll_en  = load_done & drive_level(act.pl, fld.pl_pol);
    assign rf_en   = load_done & drive_level(act.rf, fld.rf_pol);
    assign dmd1_en = load_done & drive_level(act.q1, fld.q1_pol);
    assign dmd2_en = load_done & drive_level(act.q2, fld.q2_pol);
    assign aux_a   = load_done & fld.aux_gate & act.q1;
    assign aux_b   = load_done & fld.aux_gate & ~dmd2_en;
endmodule

// File: rtl/opt_rx_seq_chk.sv
module opt_rx_seq_chk #(
    parameter int OPT_BITS   = 192,
    parameter int POS_RF_POL = 0,
    parameter int POS_PL_POL = 1,
    parameter int POS_Q1_POL = 2,
    parameter int POS_Q2_POL = 3,
    parameter int POS_AUX    = 4
) (
    input logic                clk,
    input logic                rst,
    input logic                load_done,
    input logic [OPT_BITS-1:0] opt_reg,
    input logic                run_s,
    input logic                osc_en,
    input logic                pll_en,
    input logic                rf_en,
    input logic                dmd1_en,
    input logic                dmd2_en,
    input logic                aux_a,
    input logic                aux_b
);
    logic pl_on, rf_on, q1_on, q2_on, gate;
    assign pl_on = load_done && (pll_en  == opt_reg[POS_PL_POL]);
    assign rf_on = load_done && (rf_en   == opt_reg[POS_RF_POL]);
    assign q1_on = load_done && (dmd1_en == opt_reg[POS_Q1_POL]);
    assign q2_on = load_done && (dmd2_en == opt_reg[POS_Q2_POL]);
    assign gate  = opt_reg[POS_AUX];

    AST_QUIET_BEFORE_LOAD: assert property (@(posedge clk) disable iff (rst)
        !load_done |-> !osc_en && !pll_en && !rf_en && !dmd1_en && !dmd2_en && !aux_a && !aux_b); // R3
    AST_OPT_FROZEN: assert property (@(posedge clk) disable iff (rst)
        load_done |=> load_done && $stable(opt_reg)); // R2
    AST_PL_NEEDS_OSC: assert property (@(posedge clk) disable iff (rst)
        pl_on |-> osc_en); // R5
    AST_RF_AFTER_PL: assert property (@(posedge clk) disable iff (rst)
        rf_on |-> pl_on); // R6
    AST_Q1_AFTER_RF: assert property (@(posedge clk) disable iff (rst)
        q1_on |-> rf_on); // R7
    AST_Q2_AFTER_Q1: assert property (@(posedge clk) disable iff (rst)
        q2_on |-> q1_on); // R8
    AST_AUX_B_INVERSE: assert property (@(posedge clk) disable iff (rst)
        load_done && gate |-> aux_b == !dmd2_en); // R10
    AST_AUX_GATED: assert property (@(posedge clk) disable iff (rst)
        !gate |-> !aux_a && !aux_b); // R10
    AST_RUN_DROP: assert property (@(posedge clk) disable iff (rst)
        load_done && !run_s |=> !pl_on && !rf_on && !q1_on && !q2_on && !osc_en); // R11
endmodule

bind opt_rx_seq opt_rx_seq_chk #(
    .OPT_BITS(OPT_BITS), .POS_RF_POL(POS_RF_POL), .POS_PL_POL(POS_PL_POL),
    .POS_Q1_POL(POS_Q1_POL), .POS_Q2_POL(POS_Q2_POL), .POS_AUX(POS_AUX)
) chk_i (
    .clk(clk), .rst(rst), .load_done(load_done), .opt_reg(opt_reg), .run_s(run_s),
    .osc_en(osc_en), .pll_en(pll_en), .rf_en(rf_en), .dmd1_en(dmd1_en),
    .dmd2_en(dmd2_en), .aux_a(aux_a), .aux_b(aux_b)
);

// File: tb/opt_rx_seq_tb.sv
module opt_rx_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NB = 192;
    localparam int LPA = 2, LPB = 5, LRA = 3, LRB = 7, LQ1A = 1, LQ1B = 4, LQ2A = 2, LQ2B = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ser_clk = 1'b0, ser_data = 1'b0, run_req = 1'b0, osc_ready = 1'b0;
    logic osc_en, load_done, pll_en, rf_en, dmd1_en, dmd2_en, aux_a, aux_b;
    logic [NB-1:0] opt_reg;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    opt_rx_seq #(
        .OPT_BITS(NB),
        .LEAD_PL_A(LPA), .LEAD_PL_B(LPB), .LEAD_RF_A(LRA), .LEAD_RF_B(LRB),
        .LEAD_Q1_A(LQ1A), .LEAD_Q1_B(LQ1B), .LEAD_Q2_A(LQ2A), .LEAD_Q2_B(LQ2B)
    ) dut_i (
        .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_data(ser_data),
        .run_req(run_req), .osc_ready(osc_ready), .osc_en(osc_en),
        .load_done(load_done), .opt_reg(opt_reg), .pll_en(pll_en), .rf_en(rf_en),
        .dmd1_en(dmd1_en), .dmd2_en(dmd2_en), .aux_a(aux_a), .aux_b(aux_b)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(input logic b);
        ser_data = b;
        cyc(3);
        ser_clk = 1'b1;
        cyc(3);
        ser_clk = 1'b0;
        cyc(2);
    endtask

    function automatic logic [3:0] pins();
        return {pll_en, rf_en, dmd1_en, dmd2_en};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < 32; k++) begin
            logic [NB-1:0] v;
            logic [3:0] pol, sel, inact;
            logic gate;
            int t0, t1, t2, t3;
            int tp, tr, tq1, tq2;
            pol  = k[3:0];
            sel  = k[3:0] ^ 4'b0110;
            gate = k[4];
            for (int i = 0; i < NB; i++) v[i] = ((i * 7 + k) % 3 == 0);
            // bit0 rf pol, bit1 pl pol, bit2 q1 pol, bit3 q2 pol
            v[0] = pol[2]; v[1] = pol[3]; v[2] = pol[1]; v[3] = pol[0];
            v[4] = gate;
            v[5] = sel[3]; v[6] = sel[2]; v[7] = sel[1]; v[8] = sel[0];
            inact = ~pol;     // order {pl, rf, q1, q2}
            t0 = sel[3] ? LPB : LPA;
            t1 = sel[2] ? LRB : LRA;
            t2 = sel[1] ? LQ1B : LQ1A;
            t3 = sel[0] ? LQ2B : LQ2A;

            rst = 1'b1; run_req = 1'b0; osc_ready = 1'b0; ser_clk = 1'b0;
            cyc(4);
            // R3: quiet during reset
            chk(!load_done && !osc_en && pins() == 4'b0 && !aux_a && !aux_b, "R3 reset",
                {load_done, osc_en, pins(), aux_a, aux_b}, 0);
            rst = 1'b0;
            for (int i = 0; i < NB - 1; i++) pulse(v[i]);
            // R3: not yet complete after one bit short
            chk(!load_done && pins() == 4'b0 && !osc_en, "R3 partial load",
                {load_done, osc_en, pins()}, 0);
            pulse(v[NB-1]);
            cyc(2);
            chk(load_done == 1'b1, "R1 load_done", load_done, 1);
            chk(opt_reg == v, "R1 opt_reg", opt_reg[63:0], v[63:0]);
            // R4 / R9: standby, inactive levels
            chk(!osc_en, "R4 standby osc_en", osc_en, 0);
            chk(pins() == inact, "R9 inactive levels", pins(), inact);
            chk(aux_a == 1'b0 && aux_b == (gate & ~inact[0]), "R10 aux in standby",
                {aux_a, aux_b}, {1'b0, gate & ~inact[0]});
            // R2: extra pulses ignored
            for (int j = 0; j < 5; j++) pulse(~v[j]);
            chk(opt_reg == v && load_done, "R2 extra pulses", opt_reg[63:0], v[63:0]);

            run_req = 1'b1;
            cyc(6);
            chk(osc_en == 1'b1, "R4 osc request", osc_en, 1);
            chk(pins() == inact, "R5 no enable before osc", pins(), inact);

            osc_ready = 1'b1;
            tp = -1; tr = -1; tq1 = -1; tq2 = -1;
            for (int c = 1; c <= 60; c++) begin
                @(negedge clk);
                if (tp  < 0 && pll_en  == pol[3]) tp  = c;
                if (tr  < 0 && rf_en   == pol[2]) tr  = c;
                if (tq1 < 0 && dmd1_en == pol[1]) tq1 = c;
                if (tq2 < 0 && dmd2_en == pol[0]) tq2 = c;
            end
            chk(tp == 3 + t0, "R5 pll lead", tp, 3 + t0);
            chk(tr - tp == t1, "R6 rf lead", tr - tp, t1);
            chk(tq1 - tr == t2, "R7 dmd1 lead", tq1 - tr, t2);
            chk(tq2 - tq1 == t3, "R8 dmd2 lead", tq2 - tq1, t3);
            chk(pins() == pol, "R9 active levels", pins(), pol);
            chk(aux_a == gate && aux_b == (gate & ~pol[0]), "R10 aux active",
                {aux_a, aux_b}, {gate, gate & ~pol[0]});

            run_req = 1'b0;
            cyc(4);
            chk(pins() == inact && !osc_en && !aux_a, "R11 drop to standby",
                {pins(), osc_en}, {inact, 1'b0});
            chk(opt_reg == v, "R11 options kept", opt_reg[63:0], v[63:0]);

            run_req = 1'b1;
            tp = -1;
            for (int c = 1; c <= 30; c++) begin
                @(negedge clk);
                if (tp < 0 && pll_en == pol[3]) tp = c;
            end
            chk(tp == 4 + t0, "R11 restart pll lead", tp, 4 + t0);
            run_req = 1'b0;
            osc_ready = 1'b0;
            cyc(4);
        end
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule